// File: doc/BRIEF.md
# Unsigned 8x8 Column-Compression Multiplier

This block multiplies two unsigned 8-bit operands and returns their full 16-bit product. It has no clock. The output follows the operands through combinational logic only. Each bit of one operand is ANDed with each bit of the other. This gives a matrix of 64 weighted dots, arranged in 15 columns.

The dots are reduced in stages by 3:2 counters (full adders) and 2:2 counters (half adders). Each stage has a target column height. The targets come from a schedule built backwards from a final height of 2, and each earlier target is the floor of 1.5 times the one after it. For 8-bit operands the targets are 6, 4, 3 and 2.

Columns are handled from the least significant upward. A column gets only enough counters to reach the target once the carries from the column below are counted. When the last stage leaves two rows, one adder sums them. The operand width is a parameter, and the stage count and counter placement are computed from it when the design is built.

Top module: `dadda_mul8`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product of `mcand` and `mplier`.
- R2: When either operand is zero, `product` is zero.
- R3: When either operand is 1, `product` equals the other operand, zero-extended to 16 bits.
- R4: Dot (i, j) carries the weight 2^(i+j). So when `mcand` = 2^i and `mplier` = 2^j, exactly bit i+j of `product` is set.
- R5: 255 times 255 gives 65025 (0xFE01), which uses the most significant product bit.
- R6: 128 times 128 gives 16384 (0x4000), where a single dot sits in column 14.
- R7: The block holds no state. `product` follows a change of operands without any clock edge.
- R8: Each reduction stage keeps the weighted value of the matrix. After each stage, no column holds more bits than that stage's target in the schedule 6, 4, 3, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 8 | Unsigned multiplicand |
| mplier | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product, mcand times mplier |

## Verification
A counter that is miswired, missing or placed in the wrong column changes the weighted value of the matrix. That error reaches `product` in the same evaluation as the operands that expose it, because nothing is registered. Such a fault often depends on the data and shows up for only a few operand pairs. For that reason every one of the 65536 operand pairs is compared, and the directed corners are the single-dot, all-ones and zero or unit cases. Inside the design, each stage is also checked for a preserved weighted value and for its column-height limit, so a failure points to the stage that caused it.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  localparam int MAX_COLS = 64;
  localparam int Q_HEIGHT = 0;
  localparam int Q_FULL   = 1;
  localparam int Q_HALF   = 2;

  // j-th entry of the height schedule counted from the final height of 2
  function automatic int sched_height(input int j);
    int d;
    d = 2;
    for (int i = 0; i < j; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // number of reduction stages needed for n rows
  function automatic int stage_count(input int n);
    int k;
    k = 0;
    for (int j = 0; j < 32; j++)
      if (sched_height(j) < n) k = j + 1;
    return k;
  endfunction

  function automatic int stage_target(input int n, input int s);
    return sched_height(stage_count(n) - 1 - s);
  endfunction

  function automatic int init_height(input int n, input int c);
    if (c < n) return c + 1;
    if (c < 2 * n - 1) return 2 * n - 1 - c;
    return 0;
  endfunction

  // kind Q_HEIGHT: height of column c entering stage s
  // kind Q_FULL / Q_HALF: counters placed in column c during stage s
  function automatic int plan_query(input int n, input int s, input int c, input int kind);
    int hh [MAX_COLS];
    int cin, ex, f, hf, d;
    for (int col = 0; col < MAX_COLS; col++) hh[col] = init_height(n, col);
    for (int st = 0; st <= s; st++) begin
      if (st == s && kind == Q_HEIGHT) return hh[c];
      d   = stage_target(n, st);
      cin = 0;
      for (int col = 0; col < 2 * n; col++) begin
        ex = hh[col] + cin - d;
        f  = (ex > 0) ? ex / 2 : 0;
        hf = (ex > 0) ? ex % 2 : 0;
        if (st == s && col == c) return (kind == Q_FULL) ? f : hf;
        hh[col] = hh[col] - 2 * f - hf + cin;
        cin     = f + hf;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/dadda_counter.sv
module dadda_counter (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  // 3:2 counter; tie z low for a 2:2 counter
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
  parameter int N = 8
) (
  input  logic [N-1:0]             a,
  input  logic [N-1:0]             b,
  output logic [2*N-1:0][N-1:0]    mat
);
  localparam int COLS = 2 * N;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int LO = (c < N) ? 0 : c - N + 1;
    localparam int HI = (c < N) ? c : N - 1;
    for (genvar k = 0; k < N; k++) begin : g_dot
      if (LO + k <= HI && c < COLS - 1) begin : g_and
        assign mat[c][k] = a[LO + k] & b[c - LO - k];
      end else begin : g_zero
        assign mat[c][k] = 1'b0;
      end
    end
  end

  // matrix holds popcount(a)*popcount(b) ones
  always_comb begin
    if (!$isunknown({a, b})) begin
      p_dot_count_r4: assert ($countones(mat) == $countones(a) * $countones(b))
        else $error("dot matrix population wrong");
    end
  end
endmodule

// File: rtl/dadda_stage.sv
module dadda_stage #(
  parameter int N = 8,
  parameter int S = 0
) (
  input  logic [2*N-1:0][N-1:0] mat_in,
  output logic [2*N-1:0][N-1:0] mat_out
);
  import dadda_pkg::*;

  localparam int COLS = 2 * N;
  localparam int TGT  = stage_target(N, S);

  logic [COLS-1:0][N-1:0] sum_w;
  logic [COLS-1:0][N-1:0] cy_w;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int F    = plan_query(N, S, c, Q_FULL);
    localparam int HF   = plan_query(N, S, c, Q_HALF);
    localparam int HT   = plan_query(N, S, c, Q_HEIGHT);
    localparam int PASS = HT - 3 * F - 2 * HF;
    localparam int CIN  = (c == 0) ? 0 :
                          plan_query(N, S, c - 1, Q_FULL) + plan_query(N, S, c - 1, Q_HALF);

    for (genvar k = 0; k < N; k++) begin : g_cnt
      if (k < F) begin : g_full
        dadda_counter u_fa (
          .x (mat_in[c][3*k]),
          .y (mat_in[c][3*k+1]),
          .z (mat_in[c][3*k+2]),
          .s (sum_w[c][k]),
          .co(cy_w[c][k])
        );
      end else if (k < F + HF) begin : g_half
        dadda_counter u_ha (
          .x (mat_in[c][3*F + 2*(k-F)]),
          .y (mat_in[c][3*F + 2*(k-F) + 1]),
          .z (1'b0),
          .s (sum_w[c][k]),
          .co(cy_w[c][k])
        );
      end else begin : g_none
        assign sum_w[c][k] = 1'b0;
        assign cy_w[c][k]  = 1'b0;
      end
    end

    // output column: sums, then untouched bits, then carries from below
    for (genvar j = 0; j < N; j++) begin : g_out
      if (j < F + HF) begin : g_sum
        assign mat_out[c][j] = sum_w[c][j];
      end else if (j < F + HF + PASS) begin : g_pass
        assign mat_out[c][j] = mat_in[c][3*F + 2*HF + (j - F - HF)];
      end else if (j < F + HF + PASS + CIN) begin : g_carry
        assign mat_out[c][j] = cy_w[c-1][j - F - HF - PASS];
      end else begin : g_zero
        assign mat_out[c][j] = 1'b0;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{mat_in, cy_w[COLS-1]};

  function automatic logic [COLS-1:0] weigh(input logic [COLS-1:0][N-1:0] m);
    logic [COLS-1:0] acc;
    acc = '0;
    for (int c = 0; c < COLS; c++) acc = acc + (COLS'($countones(m[c])) << c);
    return acc;
  endfunction

  always_comb begin
    if (!$isunknown(mat_in)) begin
      p_value_kept_r8: assert (weigh(mat_out) == weigh(mat_in))
        else $error("stage %0d changed the matrix value", S);
      for (int c = 0; c < COLS; c++) begin
        p_height_r8: assert ($countones(mat_out[c]) <= TGT)
          else $error("stage %0d column %0d over height %0d", S, c, TGT);
      end
    end
  end
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  assign s = x + y;
endmodule

// File: rtl/dadda_mul8.sv
module dadda_mul8 #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);
  import dadda_pkg::*;

  localparam int COLS = 2 * N;
  localparam int NS   = stage_count(N);

  logic [COLS-1:0][N-1:0] mat [NS+1];
  logic [COLS-1:0]        row_a;
  logic [COLS-1:0]        row_b;

  dadda_ppgen #(.N(N)) u_pp (
    .a  (mcand),
    .b  (mplier),
    .mat(mat[0])
  );

  for (genvar s = 0; s < NS; s++) begin : g_stage
    dadda_stage #(.N(N), .S(s)) u_stage (
      .mat_in (mat[s]),
      .mat_out(mat[s+1])
    );
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rows
    assign row_a[c] = mat[NS][c][0];
    assign row_b[c] = (N > 1) ? mat[NS][c][N > 1 ? 1 : 0] : 1'b0;
  end

  logic unused_top;
  assign unused_top = ^mat[NS];

  dadda_cpa #(.W(COLS)) u_cpa (
    .x(row_a),
    .y(row_b),
    .s(product)
  );

  always_comb begin
    if (!$isunknown({mcand, mplier})) begin
      p_product_r1: assert (product == COLS'(mcand) * COLS'(mplier))
        else $error("product mismatch");
      if (mcand == '0 || mplier == '0) begin
        p_zero_r2: assert (product == '0)
          else $error("zero operand gave nonzero product");
      end
    end
  end
endmodule

// File: tb/dadda_mul8_tb_top.sv
module dadda_mul8_tb_top;

  logic        clk = 1'b0;
  logic [7:0]  a_d;
  logic [7:0]  b_d;
  logic [15:0] prod;

  always #4 clk = ~clk;

  dadda_mul8 #(.N(8)) dut_i (
    .mcand  (a_d),
    .mplier (b_d),
    .product(prod)
  );

  typedef struct {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] exp;
    int          tag;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic string tag_name(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R1 R8";
    endcase
  endfunction

  function automatic int classify(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'd128 && b == 8'd128) return 6;
    if (a == 8'd255 && b == 8'd255) return 5;
    if (a == 8'd0 || b == 8'd0) return 2;
    if (a == 8'd1 || b == 8'd1) return 3;
    if ($countones(a) == 1 && $countones(b) == 1) return 4;
    return 1;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tg,
                       input logic [7:0] a, input logic [7:0] b);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tg, a, b, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b);
    item_t it;
    @(negedge clk);
    a_d    = a;
    b_d    = b;
    it.a   = a;
    it.b   = b;
    it.exp = 16'(a) * 16'(b);
    it.tag = classify(a, b);
    q.push_back(it);
  endtask

  // monitor: results are compared half a cycle after the operands change
  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(prod, it.exp, tag_name(it.tag), it.a, it.b);
    end
  end

  initial begin
    a_d = 8'd0;
    b_d = 8'd0;
    #3;
    check(prod, 16'd0, "R2", a_d, b_d);
    drive(8'd128, 8'd128);  // R6
    drive(8'd255, 8'd255);  // R5
    drive(8'd1,   8'd200);  // R3
    drive(8'd4,   8'd32);   // R4
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        drive(8'(i), 8'(j));
    @(posedge clk);
    @(negedge clk);
    // R7: no clock edge between operand change and sampling
    a_d = 8'd200;
    b_d = 8'd3;
    #1;
    check(prod, 16'd600, "R7", a_d, b_d);
    b_d = 8'd77;
    #1;
    check(prod, 16'd15400, "R7", a_d, b_d);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule